// File: doc/BRIEF.md
# Exception and Interrupt Control Coprocessor

This block is the system-control coprocessor of a small 32-bit processor core. It keeps the processor status word (global interrupt enable, exception-level flag and a per-line interrupt mask), the cause word (exception code and pending interrupt lines) and the exception return address. It also contains a free-running tick counter with a match register that drives interrupt line 5. The core reads and writes these registers by register number through a move-to port (registered) and a move-from port (combinational).

Each cycle the core offers a synchronous exception request with its code and the PC of the instruction concerned. Any unmasked pending interrupt is also considered. When either is present the block raises `take_exc` in the same cycle. On the following clock edge it captures the PC, the code (0 for an interrupt) and sets the exception-level flag. The core then fetches from the constant vector `vec_addr`. A return strobe clears the exception-level flag, and the core resumes at `epc_out`. For an interrupt that address is the instruction that has not yet executed.

Top module: `sysctl_cop`

## Requirements
- R1: While reset is active, and up to the first clock edge after the internal reset releases, every register reads 0 through the move-from port and `take_exc` is low.
- R2: A move-to with `mt_en`=1 writes at the clock edge. The register numbers are 9 (tick counter), 11 (match value), 12 (status), 13 (cause) and 14 (return address). Status keeps only bit 0 (interrupt enable), bit 1 (exception level) and bits [15:8] (line mask). Cause keeps only bits [6:2] (exception code). All other bits read 0. `mf_data` shows the addressed register in the same cycle, and unmapped numbers read 0.
- R3: Cause bits [15:8] show `irq_in` as sampled at the previous clock edge. Bit 13 (line 5) is additionally ORed with the timer-pending flag. Writes do not alter these bits.
- R4: `take_exc` is high in the same cycle when status bit 0 is 1, status bit 1 is 0, and some cause bit [8+i] and status bit [8+i] are both 1.
- R5: `exc_req`=1 raises `take_exc` in the same cycle whatever the enable, mask and exception-level bits are. It takes priority over a pending interrupt for the recorded code.
- R6: At the clock edge of a cycle with `take_exc`=1, the block loads `exc_pc` into the return address and sets status bit 1. It loads the cause code with `exc_code` when `exc_req`=1, else with 0. A move-to of status, cause or return address in that same cycle is discarded.
- R7: `vec_addr` is always 0x80000180.
- R8: `epc_out` always shows the return-address register. A cycle with `eret`=1 clears status bit 1 at the clock edge, unless that cycle takes an exception or writes status.
- R9: The tick counter advances by one, wrapping at 2^32, once every PRESCALE clocks. A move-to of register 9 loads it instead of the increment.
- R10: The timer-pending flag sets when an increment makes the tick counter equal the match value. A load of the counter never sets it. The flag stays set until a move-to of register 11, which clears it even in a cycle where a match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Code of the requested exception |
| exc_pc | input | 32 | PC to record if an exception or interrupt is taken this cycle |
| irq_in | input | 8 | External interrupt lines, level sensitive |
| mt_en | input | 1 | Move-to write strobe |
| mt_reg | input | 5 | Move-to register number |
| mt_data | input | 32 | Move-to write data |
| mf_reg | input | 5 | Move-from register number |
| mf_data | output | 32 | Move-from read data |
| eret | input | 1 | Exception-return command |
| take_exc | output | 1 | Redirect fetch to the vector this cycle |
| vec_addr | output | 32 | Exception vector address |
| epc_out | output | 32 | Return address for the return command |

## Verification
A wrong exception-level or enable bit shows up within one cycle. Either `take_exc` appears while an interrupt should be blocked, or it fails to appear while a masked-in line is pending. Status reads expose the same bits at once. A wrong captured PC or code is visible on `epc_out` and in cause reads from the very next cycle. A slipped prescaler or a missed match shows as a tick count that differs within PRESCALE clocks, or as a cause bit 13 that rises at the wrong count. Because every register is read back every cycle, divergence is reported on the first cycle it exists.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN     = 32;
  localparam int RN_W     = 5;
  localparam int NUM_IRQ  = 8;
  localparam int CODE_W   = 5;
  localparam int CODE_LSB = 2;
  localparam int IRQ_LSB  = 8;
  localparam int ST_IE    = 0;
  localparam int ST_EXL   = 1;

  localparam logic [RN_W-1:0] RN_COUNT   = 5'd9;
  localparam logic [RN_W-1:0] RN_COMPARE = 5'd11;
  localparam logic [RN_W-1:0] RN_STATUS  = 5'd12;
  localparam logic [RN_W-1:0] RN_CAUSE   = 5'd13;
  localparam logic [RN_W-1:0] RN_EPC     = 5'd14;

  typedef struct packed {
    logic            we;
    logic [RN_W-1:0] rn;
    logic [XLEN-1:0] wd;
  } mtc_t;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sc_timer.sv
module sc_timer
  import sc_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  mtc_t            mt,
  output logic [XLEN-1:0] count_o,
  output logic [XLEN-1:0] compare_o,
  output logic            tip_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]   pre_q, pre_d;
  logic [XLEN-1:0] count_q, count_d, compare_q, cnt_inc;
  logic            tip_q, tip_d;
  logic            tick, wr_cnt, wr_cmp, count_en;

  // next state
  always_comb begin
    tick     = (pre_q == PRE_LAST);
    pre_d    = tick ? '0 : pre_q + 1'b1;
    wr_cnt   = mt.we && (mt.rn == RN_COUNT);
    wr_cmp   = mt.we && (mt.rn == RN_COMPARE);
    cnt_inc  = count_q + 1'b1;
    count_en = wr_cnt || tick;
    count_d  = wr_cnt ? mt.wd : cnt_inc;
    if (wr_cmp)
      tip_d = 1'b0;
    else if (tick && !wr_cnt && (cnt_inc == compare_q))
      tip_d = 1'b1;
    else
      tip_d = tip_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q     <= '0;
      count_q   <= '0;
      compare_q <= '0;
      tip_q     <= 1'b0;
    end else begin
      pre_q <= pre_d;
      tip_q <= tip_d;
      if (count_en) count_q   <= count_d;
      if (wr_cmp)   compare_q <= mt.wd;
    end
  end

  assign count_o   = count_q;
  assign compare_o = compare_q;
  assign tip_o     = tip_q;

  assert_cmp_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mt.we && mt.rn == RN_COMPARE) |=> !tip_o);
  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(count_o));
  assert_load_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !tip_o) |=> !tip_o);
endmodule

// File: rtl/sc_irq_eval.sv
module sc_irq_eval
  import sc_pkg::*;
#(
  parameter int TIMER_LINE = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               tip_i,
  input  logic               ie_i,
  input  logic               exl_i,
  input  logic [NUM_IRQ-1:0] im_i,
  input  logic               exc_req_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic               take_o
);
  logic [NUM_IRQ-1:0] ip_q;
  logic               int_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= '0;
    else        ip_q <= irq_i;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    if (g == TIMER_LINE) begin : g_tmr
      assign pend_o[g] = ip_q[g] | tip_i;
    end else begin : g_ext
      assign pend_o[g] = ip_q[g];
    end
  end

  always_comb begin
    int_req = ie_i && !exl_i && (|(pend_o & im_i));
    take_o  = exc_req_i || int_req;
  end

  assert_tmr_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tip_i |-> pend_o[TIMER_LINE]);
  assert_block_exl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_i && !exc_req_i) |-> !take_o);
endmodule

// File: rtl/sc_regs.sv
module sc_regs
  import sc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  logic               exc_req_i,
  input  logic [CODE_W-1:0]  exc_code_i,
  input  logic [XLEN-1:0]    exc_pc_i,
  input  mtc_t               mt,
  input  logic               eret_i,
  output logic               ie_o,
  output logic               exl_o,
  output logic [NUM_IRQ-1:0] im_o,
  output logic [CODE_W-1:0]  code_o,
  output logic [XLEN-1:0]    epc_o
);
  logic               ie_q, ie_d, exl_q, exl_d;
  logic [NUM_IRQ-1:0] im_q, im_d;
  logic [CODE_W-1:0]  code_q, code_d;
  logic [XLEN-1:0]    epc_q, epc_d;
  logic               wr_st, wr_ca, wr_epc, code_en, epc_en;

  // next state
  always_comb begin
    wr_st   = mt.we && (mt.rn == RN_STATUS) && !take_i;
    wr_ca   = mt.we && (mt.rn == RN_CAUSE)  && !take_i;
    wr_epc  = mt.we && (mt.rn == RN_EPC)    && !take_i;
    ie_d    = wr_st ? mt.wd[ST_IE] : ie_q;
    im_d    = wr_st ? mt.wd[IRQ_LSB +: NUM_IRQ] : im_q;
    if (take_i)      exl_d = 1'b1;
    else if (wr_st)  exl_d = mt.wd[ST_EXL];
    else if (eret_i) exl_d = 1'b0;
    else             exl_d = exl_q;
    code_en = take_i || wr_ca;
    if (take_i) code_d = exc_req_i ? exc_code_i : '0;
    else        code_d = mt.wd[CODE_LSB +: CODE_W];
    epc_en  = take_i || wr_epc;
    epc_d   = take_i ? exc_pc_i : mt.wd;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      im_q   <= '0;
      code_q <= '0;
      epc_q  <= '0;
    end else begin
      ie_q  <= ie_d;
      exl_q <= exl_d;
      im_q  <= im_d;
      if (code_en) code_q <= code_d;
      if (epc_en)  epc_q  <= epc_d;
    end
  end

  assign ie_o   = ie_q;
  assign exl_o  = exl_q;
  assign im_o   = im_q;
  assign code_o = code_q;
  assign epc_o  = epc_q;

  assert_entry_exl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> exl_o);
  assert_entry_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (epc_o == $past(exc_pc_i)));
  assert_int_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !exc_req_i) |=> (code_o == '0));
  assert_eret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !take_i && !(mt.we && mt.rn == RN_STATUS)) |=> !exl_o);
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
  import sc_pkg::*;
#(
  parameter int          PRESCALE   = 4,
  parameter int          TIMER_LINE = 5,
  parameter logic [31:0] VECTOR     = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic [31:0] exc_pc,
  input  logic [7:0]  irq_in,
  input  logic        mt_en,
  input  logic [4:0]  mt_reg,
  input  logic [31:0] mt_data,
  input  logic [4:0]  mf_reg,
  output logic [31:0] mf_data,
  input  logic        eret,
  output logic        take_exc,
  output logic [31:0] vec_addr,
  output logic [31:0] epc_out
);
  logic               rst_q;
  mtc_t               mt;
  logic [XLEN-1:0]    count, compare, epc, status_rd, cause_rd;
  logic               tip, ie, exl, take;
  logic [NUM_IRQ-1:0] im, pend;
  logic [CODE_W-1:0]  code;

  assign mt = '{we: mt_en, rn: mt_reg, wd: mt_data};

  sc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q)
  );

  sc_timer #(.PRESCALE(PRESCALE)) u_tmr (
    .clk(clk), .rst_n(rst_q), .mt(mt),
    .count_o(count), .compare_o(compare), .tip_o(tip)
  );

  sc_irq_eval #(.TIMER_LINE(TIMER_LINE)) u_irq (
    .clk(clk), .rst_n(rst_q), .irq_i(irq_in), .tip_i(tip),
    .ie_i(ie), .exl_i(exl), .im_i(im), .exc_req_i(exc_req),
    .pend_o(pend), .take_o(take)
  );

  sc_regs u_regs (
    .clk(clk), .rst_n(rst_q), .take_i(take), .exc_req_i(exc_req),
    .exc_code_i(exc_code), .exc_pc_i(exc_pc), .mt(mt), .eret_i(eret),
    .ie_o(ie), .exl_o(exl), .im_o(im), .code_o(code), .epc_o(epc)
  );

  // read path
  always_comb begin
    status_rd = '0;
    status_rd[ST_IE]  = ie;
    status_rd[ST_EXL] = exl;
    status_rd[IRQ_LSB +: NUM_IRQ] = im;
    cause_rd = '0;
    cause_rd[CODE_LSB +: CODE_W]  = code;
    cause_rd[IRQ_LSB +: NUM_IRQ]  = pend;
    case (mf_reg)
      RN_COUNT:   mf_data = count;
      RN_COMPARE: mf_data = compare;
      RN_STATUS:  mf_data = status_rd;
      RN_CAUSE:   mf_data = cause_rd;
      RN_EPC:     mf_data = epc;
      default:    mf_data = '0;
    endcase
  end

  assign take_exc = take;
  assign vec_addr = VECTOR;
  assign epc_out  = epc;

  assert_take_sync_R5: assert property (@(posedge clk) disable iff (!rst_q)
    exc_req |-> take_exc);
  assert_take_gate_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (!exc_req && !ie) |-> !take_exc);
endmodule

// File: tb/sim_sysctl_cop.sv
`timescale 1ns/1ps
module sim_sysctl_cop;
  localparam int PRE = 4;

  logic        clk = 1'b0;
  logic        rst_n, exc_req, mt_en, eret;
  logic [4:0]  exc_code, mt_reg, mf_reg;
  logic [31:0] exc_pc, mt_data;
  logic [7:0]  irq_in;
  logic [31:0] mf_data, vec_addr, epc_out;
  logic        take_exc;

  always #2.5 clk = ~clk;

  sysctl_cop #(.PRESCALE(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .exc_pc(exc_pc), .irq_in(irq_in), .mt_en(mt_en), .mt_reg(mt_reg),
    .mt_data(mt_data), .mf_reg(mf_reg), .mf_data(mf_data), .eret(eret),
    .take_exc(take_exc), .vec_addr(vec_addr), .epc_out(epc_out)
  );

  // reference state
  logic [31:0] m_count, m_compare, m_epc;
  logic        m_tip, m_ie, m_exl;
  logic [7:0]  m_im, m_ipq;
  logic [4:0]  m_code;
  int          m_pre, hold;
  int          checks = 0, fails = 0;
  bit          done = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [7:0] m_pend();
    return m_ipq | (m_tip ? 8'h20 : 8'h00);
  endfunction
  function automatic logic m_take();
    return exc_req || (m_ie && !m_exl && (|(m_pend() & m_im)));
  endfunction
  function automatic logic [31:0] m_status();
    return {16'h0, m_im, 6'h0, m_exl, m_ie};
  endfunction
  function automatic logic [31:0] m_cause();
    return {16'h0, m_pend(), 1'b0, m_code, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic rd(input logic [4:0] r, input logic [31:0] e, input string tag);
    mf_reg = r;
    #0.05;
    chk(tag, mf_data, e);
  endtask

  task automatic compare_all();
    #0.2;
    chk("R4 R5 take_exc", {31'b0, take_exc}, {31'b0, m_take()});
    chk("R7 vec_addr", vec_addr, 32'h8000_0180);
    chk("R8 epc_out", epc_out, m_epc);
    rd(5'd9,  m_count,    "R9 count read");
    rd(5'd11, m_compare,  "R2 compare read");
    rd(5'd12, m_status(), "R2 R6 R8 status read");
    rd(5'd13, m_cause(),  "R3 R6 R10 cause read");
    rd(5'd14, m_epc,      "R2 R6 return address read");
    rd(5'd3,  32'h0,      "R2 unmapped read");
    rd(5'd31, 32'h0,      "R2 unmapped read");
  endtask

  task automatic model_update();
    logic tk, tick, wc, wp, ws, wa, we;
    if (hold > 0) begin hold--; return; end
    tk   = m_take();
    tick = (m_pre == PRE - 1);
    m_pre = tick ? 0 : m_pre + 1;
    wc = mt_en && mt_reg == 5'd9;
    wp = mt_en && mt_reg == 5'd11;
    ws = mt_en && mt_reg == 5'd12 && !tk;
    wa = mt_en && mt_reg == 5'd13 && !tk;
    we = mt_en && mt_reg == 5'd14 && !tk;
    if (wc) m_count = mt_data;
    else if (tick) begin
      m_count = m_count + 1;
      if (m_count == m_compare) m_tip = 1'b1;
    end
    if (wp) begin m_compare = mt_data; m_tip = 1'b0; end
    if (tk) m_exl = 1'b1;
    else if (ws) begin m_ie = mt_data[0]; m_exl = mt_data[1]; m_im = mt_data[15:8]; end
    else if (eret) m_exl = 1'b0;
    if (tk) m_code = exc_req ? exc_code : 5'd0;
    else if (wa) m_code = mt_data[6:2];
    if (tk) m_epc = exc_pc;
    else if (we) m_epc = mt_data;
    m_ipq = irq_in;
  endtask

  task automatic step();
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    exc_req = 1'b0; mt_en = 1'b0; eret = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic mtc(input logic [4:0] r, input logic [31:0] d);
    mt_en = 1'b1; mt_reg = r; mt_data = d;
    step();
  endtask

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exc_req = 1'b0; exc_code = '0; exc_pc = '0; irq_in = '0;
    mt_en = 1'b0; mt_reg = '0; mt_data = '0; mf_reg = '0; eret = 1'b0;
    m_count = '0; m_compare = '0; m_epc = '0; m_tip = 1'b0; m_ie = 1'b0;
    m_exl = 1'b0; m_im = '0; m_ipq = '0; m_code = '0; m_pre = 0; hold = 2;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 take_exc in reset", {31'b0, take_exc}, 32'h0);
    rd(5'd9,  32'h0, "R1 count in reset");
    rd(5'd11, 32'h0, "R1 compare in reset");
    rd(5'd12, 32'h0, "R1 status in reset");
    rd(5'd13, 32'h0, "R1 cause in reset");
    rd(5'd14, 32'h0, "R1 return address in reset");
    rst_n = 1'b1;
    idle(4);

    // R4 R6: interrupt on line 2 enabled and masked in
    mtc(5'd12, 32'h0000_0401);
    exc_pc = 32'h0040_0020;
    irq_in = 8'h04;
    idle(3);
    irq_in = 8'h00;
    eret = 1'b1; step();
    idle(2);

    // R5 R6: synchronous exception while a status write is attempted
    exc_req = 1'b1; exc_code = 5'd12; exc_pc = 32'h0040_0100;
    mt_en = 1'b1; mt_reg = 5'd12; mt_data = 32'h0;
    step();
    idle(2);
    eret = 1'b1; step();

    // R4: enable off, line pending, no take
    mtc(5'd12, 32'h0000_0400);
    irq_in = 8'h04;
    idle(3);
    mtc(5'd12, 32'h0000_0401);
    idle(2);
    irq_in = 8'h00;
    eret = 1'b1; step();
    idle(2);

    // R2: cause code write, return address write
    mtc(5'd13, 32'hFFFF_FFFF);
    mtc(5'd14, 32'h1234_5678);
    mtc(5'd13, 32'h0);

    // R9 R10: timer match on line 5
    mtc(5'd12, 32'h0000_2001);
    mtc(5'd11, m_count + 32'd10);
    idle(60);
    mtc(5'd11, 32'h0);
    eret = 1'b1; step();
    idle(3);
    // R10: loading the counter with the match value does not set pending
    mtc(5'd11, 32'd100);
    mtc(5'd9, 32'd100);
    idle(12);
    // R9: wrap
    mtc(5'd9, 32'hFFFF_FFFE);
    mtc(5'd11, 32'h0000_0001);
    idle(16);
    mtc(5'd11, 32'h0);
    eret = 1'b1; step();

    // mixed stimulus
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] rsel;
      rng = xs(rng);
      exc_req  = rng[0] & rng[1] & rng[2];
      exc_code = rng[7:3];
      exc_pc   = {rng[31:2], 2'b00};
      irq_in   = rng[16] ? rng[15:8] & rng[31:24] : 8'h00;
      mt_en    = rng[17] & rng[18];
      case (rng[21:19])
        3'd0: rsel = 5'd9;
        3'd1: rsel = 5'd11;
        3'd2: rsel = 5'd12;
        3'd3: rsel = 5'd13;
        3'd4: rsel = 5'd14;
        3'd5: rsel = 5'd0;
        3'd6: rsel = 5'd12;
        default: rsel = 5'd11;
      endcase
      mt_reg  = rsel;
      mt_data = rng[22] ? m_count + {28'h0, rng[26:23]} : xs(rng);
      if (rsel == 5'd12 && rng[29]) mt_data[1] = 1'b0;
      eret    = rng[27] & rng[28];
      step();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule